// File: doc/BRIEF.md
# Host Bus Register Access Front-End

This block sits between a host processor bus and the control registers of one serial communications channel. It decodes host read and write cycles into register accesses. The first write after a hardware reset is always taken as the bus configuration, whatever address or data/command level comes with it. That configuration word sets three things: whether addresses come from the shared address/data lines or from an indirect pointer, how the captured address bits are aligned, and whether the host bus is 8 or 16 bits wide. It governs every later cycle until the next hardware reset.

In multiplexed mode, an address strobe captures a 7-bit register address from the address/data lines. Address bits [6:1] pick a register word, and bit 0 picks the byte on an 8-bit bus. In non-multiplexed mode, the host first writes a pointer into the command/address register. The next command access reaches the register named by that pointer, and the pointer then returns to zero. Driving the data/command pin high bypasses both schemes and reaches the receive data input (on reads) or the transmit data register (on writes). The command/address register also holds a channel soft-reset bit with a strict release rule.

The sequencer has three states. `ST_UNCFG` leaves on any write to `ST_IDLE`; that is the configuration capture. `ST_IDLE` goes to `ST_ARMED` on a pointer load, which is a non-multiplexed command write landing on the low part of the command/address register. `ST_ARMED` stays in `ST_ARMED` on another pointer load. `ST_ARMED` returns to `ST_IDLE` on any other command access, which clears the pointer. Only a hardware reset brings the sequencer back to `ST_UNCFG`.

Top module: `hbr_host_front`

## Requirements
- R1: After hardware reset, the first write is stored as the bus configuration, even when data/command is high or any address is presented. Bit 0 is the shift select, bit 1 selects non-multiplexed mode, and bit 2 selects a 16-bit bus. Before that write, reads return zero. The configuration write itself changes no register and does not load transmit data.
- R2: After the configuration write, no later write alters the configuration until the next hardware reset.
- R3: In multiplexed mode with shift select clear, `as_i` captures the register address from `ad_i[6:0]` and `ad_i[7]` is ignored. Bits [6:1] form the register index: 0 is the command/address register, 1 is the clock mode register, and 2 to 5 are general control registers.
- R4: In multiplexed mode with shift select set, the register address is captured from `ad_i[7:1]`.
- R5: With `dc_i` high, the captured or pointer address is ignored. A read returns `rx_data_i` and pulses `rx_take_o` for one cycle. A write loads `txd_o` and pulses `tx_load_o` for one cycle. On an 8-bit bus only the low byte is used and the upper byte is zero.
- R6: In non-multiplexed mode, a command write to the command/address register loads bits [6:0] as a pointer. The next command access reaches the pointed register, and afterwards the pointer reads back as zero, so the following command access reaches the command/address register.
- R7: Accesses with `dc_i` high leave the indirect pointer unchanged.
- R8: Writing 1 to bit 7 of the command/address register sets `chan_rst_o`. While it is set, the clock mode and general registers read zero, writes to them are ignored, and transmit data writes are ignored.
- R9: Channel reset is released only by writing all zeros to the full register on a 16-bit bus, or to its low byte on an 8-bit bus. A zero bit 7 with other bits set does not release it.
- R10: After hardware reset, `clk_sel_o` (the clock mode register) is zero, meaning no clock source is selected, and `chan_rst_o`, `txd_o` and `rdata_o` are zero.
- R11: On an 8-bit bus, each register is accessed one byte at a time. Address bit 0 = 0 selects the low byte. Written data comes from `ad_i[7:0]`, and read data is returned in `rdata_o[7:0]`.
- R12: Reads of unimplemented register indices (6 and above) return zero. Writes to them leave every implemented register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| as_i | input | 1 | Address strobe (multiplexed mode) |
| wr_i | input | 1 | Single-cycle write strobe |
| rd_i | input | 1 | Single-cycle read strobe |
| dc_i | input | 1 | Data/command select, high = data registers |
| ad_i | input | 16 | Shared address/data lines |
| rx_data_i | input | 16 | Receive data presented to host reads |
| rdata_o | output | 16 | Read data, valid the cycle after `rd_i` |
| txd_o | output | 16 | Transmit data register |
| tx_load_o | output | 1 | One-cycle pulse on transmit data write |
| rx_take_o | output | 1 | One-cycle pulse on receive data read |
| chan_rst_o | output | 1 | Channel soft reset |
| clk_sel_o | output | 16 | Clock mode register contents |

## Verification
Each addressing path is driven with address patterns chosen so that a wrong decode reaches a register holding a different known value. Examples are an address with bit 7 set under shift-clear, and the same address byte read under shift-set, which must reach the clock mode register instead of the general register. Pointer sequences check four things: load then access, the following access falling back to the command/address register, a pointer aimed at the clock mode register, and data/command accesses interleaved between a load and its use. Channel-reset release is tried with a nonzero high byte, with a write to the high byte alone, and with the correct zero write, on both bus widths. Unimplemented indices are probed at the first index past the general registers and at an index that would alias into them if decoding were truncated.

// File: rtl/hbr_pkg.sv
package hbr_pkg;

    typedef enum logic [1:0] {
        ST_UNCFG = 2'd0,
        ST_IDLE  = 2'd1,
        ST_ARMED = 2'd2
    } seq_state_e;

    // bit 2: 16-bit bus, bit 1: non-multiplexed, bit 0: shift select
    typedef struct packed {
        logic wide;
        logic nonmux;
        logic shift;
    } bus_cfg_t;

    localparam int CCAR_IDX = 0;
    localparam int CMCR_IDX = 1;
    localparam int GEN_BASE = 2;
    localparam int RST_BIT  = 7;

endpackage

// File: rtl/hbr_addr_latch.sv
module hbr_addr_latch
    import hbr_pkg::*;
#(
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          as_i,
    input  logic [AW:0]   ad_i,
    input  bus_cfg_t      cfg_i,
    input  logic [AW-1:0] ptr_i,
    output logic [AW-1:0] eff_addr_o
);

    logic [AW-1:0] lat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q <= '0;
        end else if (as_i) begin
            lat_q <= cfg_i.shift ? ad_i[AW:1] : ad_i[AW-1:0];
        end
    end

    assign eff_addr_o = cfg_i.nonmux ? ptr_i : lat_q;

endmodule

// File: rtl/hbr_seq.sv
module hbr_seq
    import hbr_pkg::*;
#(
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic          rd_i,
    input  logic          dc_i,
    input  logic [AW-1:0] wdata_i,
    input  logic [AW-1:0] eff_addr_i,
    output seq_state_e    state_o,
    output bus_cfg_t      cfg_o,
    output logic [AW-1:0] ptr_o
);

    seq_state_e    state_q, state_d;
    bus_cfg_t      cfg_q;
    logic [AW-1:0] ptr_q;
    logic          cmd_acc, ccar_lo, ptr_load;

    assign cmd_acc  = (wr_i | rd_i) & ~dc_i;
    assign ccar_lo  = (eff_addr_i[AW-1:1] == '0) && (cfg_q.wide || !eff_addr_i[0]);
    assign ptr_load = wr_i & ~dc_i & ccar_lo & cfg_q.nonmux & (state_q != ST_UNCFG);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_UNCFG;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_UNCFG: if (wr_i)          state_d = ST_IDLE;
            ST_IDLE:  if (ptr_load)      state_d = ST_ARMED;
            ST_ARMED: if (ptr_load)      state_d = ST_ARMED;
                      else if (cmd_acc)  state_d = ST_IDLE;
            default:                     state_d = ST_UNCFG;
        endcase
    end

    // outputs: configuration and pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
            ptr_q <= '0;
        end else begin
            if (state_q == ST_UNCFG && wr_i) cfg_q <= bus_cfg_t'(wdata_i[2:0]);
            if (ptr_load)                                ptr_q <= wdata_i;
            else if (state_q == ST_ARMED && cmd_acc)     ptr_q <= '0;
        end
    end

    assign state_o = state_q;
    assign cfg_o   = cfg_q;
    assign ptr_o   = ptr_q;

    p_cfg_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_UNCFG) |=> ($stable(cfg_q) && state_q != ST_UNCFG));

    p_dc_keeps_ptr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_UNCFG && dc_i && (wr_i || rd_i)) |=> $stable(ptr_q));

    p_armed_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && !dc_i && rd_i) |=> (ptr_q == '0 && state_q == ST_IDLE));

    p_mux_no_ptr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_q.nonmux) |-> (ptr_q == '0 && state_q != ST_ARMED));

endmodule

// File: rtl/hbr_regfile.sv
module hbr_regfile
    import hbr_pkg::*;
#(
    parameter int NUM_GEN = 4,
    parameter int DW      = 16,
    parameter int AW      = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic          rd_i,
    input  logic          dc_i,
    input  logic          cfg_valid_i,
    input  logic          wide_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] eff_addr_i,
    input  logic [AW-1:0] ptr_i,
    input  logic [DW-1:0] rx_data_i,
    output logic [DW-1:0] rdata_o,
    output logic [DW-1:0] txd_o,
    output logic          tx_load_o,
    output logic          rx_take_o,
    output logic          chan_rst_o,
    output logic [DW-1:0] clk_sel_o
);

    localparam int BW = DW / 2;
    localparam int IW = AW - 1;

    logic [IW-1:0] idx;
    logic          bsel, we, we_lo, we_hi, rel_ok, tx_we;
    logic [DW-1:0] wval, rd_word, rd_fmt, cmcr_q;
    logic [BW-1:0] ccar_hi_q;
    logic          chan_rst_q;
    logic [NUM_GEN-1:0][DW-1:0] gen_w;

    assign idx    = eff_addr_i[AW-1:1];
    assign bsel   = eff_addr_i[0];
    assign we     = wr_i & ~dc_i & cfg_valid_i;
    assign we_lo  = wide_i | ~bsel;
    assign we_hi  = wide_i | bsel;
    assign wval   = wide_i ? wdata_i : {wdata_i[BW-1:0], wdata_i[BW-1:0]};
    assign rel_ok = wide_i ? (wdata_i == '0) : (wdata_i[BW-1:0] == '0);
    assign tx_we  = wr_i & dc_i & cfg_valid_i & ~chan_rst_q;

    function automatic logic [DW-1:0] lane_merge(input logic [DW-1:0] old,
                                                 input logic [DW-1:0] val,
                                                 input logic hi, input logic lo);
        return {hi ? val[DW-1:BW] : old[DW-1:BW], lo ? val[BW-1:0] : old[BW-1:0]};
    endfunction

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
        localparam logic [IW-1:0] MY_IDX = IW'(GEN_BASE + g);
        logic [DW-1:0] r_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  r_q <= '0;
            else if (chan_rst_q)         r_q <= '0;
            else if (we && idx == MY_IDX) r_q <= lane_merge(r_q, wval, we_hi, we_lo);
        end
        assign gen_w[g] = r_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmcr_q     <= '0;
            ccar_hi_q  <= '0;
            chan_rst_q <= 1'b0;
        end else begin
            if (chan_rst_q)
                cmcr_q <= '0;
            else if (we && idx == IW'(CMCR_IDX))
                cmcr_q <= lane_merge(cmcr_q, wval, we_hi, we_lo);
            if (we && idx == IW'(CCAR_IDX)) begin
                if (we_hi) ccar_hi_q <= wval[DW-1:BW];
                if (we_lo) begin
                    if (wval[RST_BIT]) chan_rst_q <= 1'b1;
                    else if (rel_ok)   chan_rst_q <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        rd_word = '0;
        if (idx == IW'(CCAR_IDX)) rd_word = {ccar_hi_q, chan_rst_q, ptr_i[BW-2:0]};
        if (idx == IW'(CMCR_IDX)) rd_word = cmcr_q;
        for (int k = 0; k < NUM_GEN; k++) begin
            if (idx == IW'(GEN_BASE + k)) rd_word = gen_w[k];
        end
        if (wide_i)    rd_fmt = rd_word;
        else if (bsel) rd_fmt = DW'(rd_word[DW-1:BW]);
        else           rd_fmt = DW'(rd_word[BW-1:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_o   <= '0;
            txd_o     <= '0;
            tx_load_o <= 1'b0;
            rx_take_o <= 1'b0;
        end else begin
            tx_load_o <= tx_we;
            rx_take_o <= rd_i & dc_i & cfg_valid_i;
            if (tx_we) txd_o <= wide_i ? wdata_i : DW'(wdata_i[BW-1:0]);
            if (rd_i) begin
                if (!cfg_valid_i) rdata_o <= '0;
                else if (dc_i)    rdata_o <= wide_i ? rx_data_i : DW'(rx_data_i[BW-1:0]);
                else              rdata_o <= rd_fmt;
            end
        end
    end

    assign chan_rst_o = chan_rst_q;
    assign clk_sel_o  = cmcr_q;

    p_tx_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load_o |-> $past(wr_i && dc_i));

    p_rx_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_take_o |-> $past(rd_i && dc_i));

    p_rst_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        chan_rst_q |=> (clk_sel_o == '0 && !tx_load_o));

    p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(chan_rst_q) |-> $past(wr_i && !dc_i && idx == IW'(CCAR_IDX)));

endmodule

// File: rtl/hbr_host_front.sv
module hbr_host_front
    import hbr_pkg::*;
#(
    parameter int NUM_GEN = 4,
    parameter int DW      = 16,
    parameter int AW      = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          as_i,
    input  logic          wr_i,
    input  logic          rd_i,
    input  logic          dc_i,
    input  logic [DW-1:0] ad_i,
    input  logic [DW-1:0] rx_data_i,
    output logic [DW-1:0] rdata_o,
    output logic [DW-1:0] txd_o,
    output logic          tx_load_o,
    output logic          rx_take_o,
    output logic          chan_rst_o,
    output logic [DW-1:0] clk_sel_o
);

    seq_state_e    state;
    bus_cfg_t      cfg;
    logic [AW-1:0] ptr, eff_addr;

    hbr_addr_latch #(.AW(AW)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .as_i       (as_i),
        .ad_i       (ad_i[AW:0]),
        .cfg_i      (cfg),
        .ptr_i      (ptr),
        .eff_addr_o (eff_addr)
    );

    hbr_seq #(.AW(AW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (wr_i),
        .rd_i       (rd_i),
        .dc_i       (dc_i),
        .wdata_i    (ad_i[AW-1:0]),
        .eff_addr_i (eff_addr),
        .state_o    (state),
        .cfg_o      (cfg),
        .ptr_o      (ptr)
    );

    hbr_regfile #(.NUM_GEN(NUM_GEN), .DW(DW), .AW(AW)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_i        (wr_i),
        .rd_i        (rd_i),
        .dc_i        (dc_i),
        .cfg_valid_i (state != ST_UNCFG),
        .wide_i      (cfg.wide),
        .wdata_i     (ad_i),
        .eff_addr_i  (eff_addr),
        .ptr_i       (ptr),
        .rx_data_i   (rx_data_i),
        .rdata_o     (rdata_o),
        .txd_o       (txd_o),
        .tx_load_o   (tx_load_o),
        .rx_take_o   (rx_take_o),
        .chan_rst_o  (chan_rst_o),
        .clk_sel_o   (clk_sel_o)
    );

endmodule

// File: tb/hbr_host_front_tb.sv
module hbr_host_front_tb_top;

    logic        clk = 1'b0;
    logic        rst_n, as_i, wr_i, rd_i, dc_i;
    logic [15:0] ad_i, rx_data_i;
    logic [15:0] rdata_o, txd_o, clk_sel_o;
    logic        tx_load_o, rx_take_o, chan_rst_o;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    hbr_host_front dut_i (
        .clk(clk), .rst_n(rst_n), .as_i(as_i), .wr_i(wr_i), .rd_i(rd_i),
        .dc_i(dc_i), .ad_i(ad_i), .rx_data_i(rx_data_i), .rdata_o(rdata_o),
        .txd_o(txd_o), .tx_load_o(tx_load_o), .rx_take_o(rx_take_o),
        .chan_rst_o(chan_rst_o), .clk_sel_o(clk_sel_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // address for shift clear: bits [6:1] index, bit 0 byte
    function automatic logic [15:0] a0(input int idx, input int b);
        return 16'(idx * 2 + b);
    endfunction
    // address for shift set: same field moved up one bit
    function automatic logic [15:0] a1(input int idx, input int b);
        return 16'((idx * 2 + b) * 2);
    endfunction

    task automatic hw_reset();
        rst_n = 1'b0; as_i = 0; wr_i = 0; rd_i = 0; dc_i = 0; ad_i = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic strobe(input logic [15:0] a);
        as_i = 1'b1; ad_i = a;
        @(negedge clk);
        as_i = 1'b0;
    endtask

    task automatic bus_wr(input logic dc, input logic [15:0] d, output logic ld);
        wr_i = 1'b1; dc_i = dc; ad_i = d;
        @(negedge clk);
        wr_i = 1'b0; dc_i = 1'b0;
        ld = tx_load_o;
    endtask

    task automatic bus_rd(input logic dc, output logic [15:0] d, output logic tk);
        rd_i = 1'b1; dc_i = dc;
        @(negedge clk);
        rd_i = 1'b0; dc_i = 1'b0;
        d = rdata_o; tk = rx_take_o;
    endtask

    task automatic mux_wr(input logic [15:0] a, input logic [15:0] d);
        logic ld;
        strobe(a);
        bus_wr(1'b0, d, ld);
    endtask

    task automatic mux_rd(input logic [15:0] a, output logic [15:0] d);
        logic tk;
        strobe(a);
        bus_rd(1'b0, d, tk);
    endtask

    task automatic t_reset_and_config();
        logic [15:0] d; logic f;
        hw_reset();
        chk("R10", "clk_sel after reset", clk_sel_o, 16'h0000);
        chk("R10", "chan_rst after reset", {15'h0, chan_rst_o}, 16'h0000);
        chk("R10", "txd after reset", txd_o, 16'h0000);
        bus_rd(1'b0, d, f);
        chk("R1", "read before config", d, 16'h0000);
        bus_wr(1'b1, 16'h0004, f);   // dc high, still the configuration
        chk("R1", "config write no tx load", {15'h0, f}, 16'h0000);
        chk("R1", "config write txd untouched", txd_o, 16'h0000);
        mux_wr(a0(2, 0), 16'h0F0F);
        mux_rd(a0(2, 0), d);
        chk("R1", "config gives 16-bit mux", d, 16'h0F0F);
    endtask

    task automatic t_mux_shift0();
        logic [15:0] d; logic f;
        hw_reset();
        bus_wr(1'b0, 16'h0004, f);
        mux_wr(a0(2, 0), 16'h1234);
        mux_wr(a0(1, 0), 16'h00A5);
        chk("R3", "clock mode written", clk_sel_o, 16'h00A5);
        mux_rd(a0(2, 0) | 16'h0080, d);
        chk("R3", "bit 7 ignored with shift clear", d, 16'h1234);
        bus_wr(1'b1, 16'h0003, f);
        chk("R2", "later dc write goes to tx", txd_o, 16'h0003);
        mux_wr(a0(2, 0), 16'h0007);
        mux_rd(a0(2, 0), d);
        chk("R2", "config unchanged after writes", d, 16'h0007);
    endtask

    task automatic t_mux_shift1();
        logic [15:0] d; logic f;
        hw_reset();
        bus_wr(1'b0, 16'h0005, f);
        mux_wr(a1(2, 0), 16'hBEEF);
        mux_rd(a1(2, 0), d);
        chk("R4", "shifted address reaches gen2", d, 16'hBEEF);
        mux_rd(a0(2, 0), d);        // ad=0x04 -> addr 0x02 -> clock mode
        chk("R4", "unshifted pattern hits clock mode", d, 16'h0000);
    endtask

    task automatic t_dc_path();
        logic [15:0] d; logic f;
        hw_reset();
        bus_wr(1'b0, 16'h0004, f);
        mux_wr(a0(2, 0), 16'h0777);
        rx_data_i = 16'h5A3C;
        bus_rd(1'b1, d, f);
        chk("R5", "dc read returns rx data", d, 16'h5A3C);
        chk("R5", "rx_take pulse", {15'h0, f}, 16'h0001);
        bus_wr(1'b1, 16'h1357, f);
        chk("R5", "dc write loads txd", txd_o, 16'h1357);
        chk("R5", "tx_load pulse", {15'h0, f}, 16'h0001);
        @(negedge clk);
        chk("R5", "tx_load one cycle", {15'h0, tx_load_o}, 16'h0000);
        bus_rd(1'b0, d, f);
        chk("R5", "latched register untouched by dc write", d, 16'h0777);
    endtask

    task automatic t_nonmux_ptr();
        logic [15:0] d; logic f;
        hw_reset();
        bus_wr(1'b0, 16'h0006, f);
        bus_wr(1'b0, 16'h0004, f);
        bus_wr(1'b0, 16'hCAFE, f);
        bus_wr(1'b0, 16'h0004, f);
        bus_rd(1'b0, d, f);
        chk("R6", "pointed read", d, 16'hCAFE);
        bus_rd(1'b0, d, f);
        chk("R6", "pointer cleared, ccar read", d, 16'h0000);
        bus_wr(1'b0, 16'h0002, f);
        bus_wr(1'b0, 16'h0011, f);
        chk("R6", "pointer to clock mode", clk_sel_o, 16'h0011);
        rx_data_i = 16'h0101;
        bus_wr(1'b0, 16'h0004, f);
        bus_wr(1'b1, 16'h2222, f);
        bus_rd(1'b1, d, f);
        chk("R7", "dc read inside pointer window", d, 16'h0101);
        bus_rd(1'b0, d, f);
        chk("R7", "pointer survives dc accesses", d, 16'hCAFE);
    endtask

    task automatic t_chan_reset16();
        logic [15:0] d; logic f;
        hw_reset();
        bus_wr(1'b0, 16'h0004, f);
        mux_wr(a0(2, 0), 16'h7777);
        mux_wr(a0(1, 0), 16'h0003);
        bus_wr(1'b1, 16'hAAAA, f);
        mux_wr(a0(0, 0), 16'h0080);
        chk("R8", "chan_rst set", {15'h0, chan_rst_o}, 16'h0001);
        mux_rd(a0(2, 0), d);
        chk("R8", "gen reg held zero", d, 16'h0000);
        chk("R8", "clock mode held zero", clk_sel_o, 16'h0000);
        mux_wr(a0(2, 0), 16'h1111);
        mux_rd(a0(2, 0), d);
        chk("R8", "write ignored in reset", d, 16'h0000);
        bus_wr(1'b1, 16'h9999, f);
        chk("R8", "tx write ignored in reset", txd_o, 16'hAAAA);
        mux_wr(a0(0, 0), 16'hFF00);
        chk("R9", "nonzero high byte keeps reset", {15'h0, chan_rst_o}, 16'h0001);
        mux_wr(a0(0, 0), 16'h0000);
        chk("R9", "zero word releases", {15'h0, chan_rst_o}, 16'h0000);
        mux_wr(a0(2, 0), 16'h4321);
        mux_rd(a0(2, 0), d);
        chk("R9", "writes work after release", d, 16'h4321);
    endtask

    task automatic t_byte_bus();
        logic [15:0] d; logic f;
        hw_reset();
        bus_wr(1'b0, 16'h0000, f);
        mux_wr(a0(2, 0), 16'hAB34);
        mux_wr(a0(2, 1), 16'h0012);
        mux_rd(a0(2, 0), d);
        chk("R11", "low byte read", d, 16'h0034);
        mux_rd(a0(2, 1), d);
        chk("R11", "high byte read", d, 16'h0012);
        mux_wr(a0(0, 0), 16'h0080);
        chk("R8", "8-bit reset set", {15'h0, chan_rst_o}, 16'h0001);
        mux_wr(a0(0, 1), 16'h0000);
        chk("R9", "high byte zero keeps reset", {15'h0, chan_rst_o}, 16'h0001);
        mux_wr(a0(0, 0), 16'hFF00);   // low byte zero on an 8-bit bus
        chk("R9", "low byte zero releases", {15'h0, chan_rst_o}, 16'h0000);
    endtask

    task automatic t_unimpl();
        logic [15:0] d;
        logic f;
        hw_reset();
        bus_wr(1'b0, 16'h0004, f);
        mux_wr(a0(2, 0), 16'h5555);
        mux_wr(a0(5, 0), 16'h6666);
        mux_wr(a0(10, 0), 16'hFFFF);
        mux_wr(a0(6, 0), 16'hEEEE);
        mux_rd(a0(10, 0), d);
        chk("R12", "index 10 reads zero", d, 16'h0000);
        mux_rd(a0(6, 0), d);
        chk("R12", "index 6 reads zero", d, 16'h0000);
        mux_rd(a0(2, 0), d);
        chk("R12", "gen2 not aliased", d, 16'h5555);
        mux_rd(a0(5, 0), d);
        chk("R12", "last gen reg intact", d, 16'h6666);
        chk("R12", "clock mode intact", clk_sel_o, 16'h0000);
    endtask

    initial begin
        rx_data_i = '0;
        t_reset_and_config();
        t_mux_shift0();
        t_mux_shift1();
        t_dc_path();
        t_nonmux_ptr();
        t_chan_reset16();
        t_byte_bus();
        t_unimpl();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule